// File: doc/BRIEF.md
# TLB Context Register Updater

This block keeps two software-visible registers that together form a page-table pointer for a translation miss handler. The first is a 32-bit field mask. It selects one run of contiguous one bits. The second is the context word. Software stores the page-table base in the context word. When the memory management unit reports a translation exception, the bits of the context word chosen by the mask are replaced in a single clock with the high-order bits of the faulting virtual address. The handler can then use the context word directly as the address of the page-table entry.

The mask sets both the position and the width of the address field at run time. This lets one core support different page sizes and entry sizes. Some mask bits may be hardwired by parameter. Software finds out which bits are implemented by writing all zeros and then all ones, reading the mask back each time. In the default build, bits 31:30 and 1:0 are fixed at zero.

Top module: `ctx_ptr_unit`

## Requirements
- R1: The first synchronous active-low reset clock clears the context word to 0x00000000 and sets the mask to 0x007FFFF0.
- R2: On a clock with `exc_valid` high and a mask whose run is n bits wide with lowest set bit at position lo, context bit lo+i takes faulting-address bit 32-n+i for each i in 0..n-1. The top mask bit therefore receives address bit 31. This holds for the default mask 0x007FFFF0 and for the widest implemented mask 0x3FFFFFFC.
- R3: An exception leaves every context bit outside the mask at its previous value.
- R4: The masks 0x003FFFF8, 0x007FFFF8 and 0x00FFFFF8 load address bits [31:13], [31:12] and [31:11], starting at context bit 3.
- R5: Mask bits 31:30 and 1:0 are read-only zero. Writing 0x00000000 reads back 0x00000000. Writing 0xFFFFFFFF reads back 0x3FFFFFFC.
- R6: When a context write and an exception fall on the same clock, masked bits take the address and all other bits take the write data.
- R7: With an all-zero mask, an exception changes no context bit.
- R8: A context write without an exception replaces the whole word on the next clock. A mask write takes effect for exceptions from the next clock on, so an exception on the same clock uses the old mask.
- R9: With no write and no exception, the context word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Mask register write enable |
| cfg_wdata | input | 32 | Mask write data |
| cfg_rdata | output | 32 | Mask register readback |
| ctx_we | input | 1 | Context word write enable |
| ctx_wdata | input | 32 | Context write data |
| ctx_rdata | output | 32 | Context word readback |
| exc_valid | input | 1 | Translation exception strobe, one clock per event |
| exc_vaddr | input | 32 | Faulting virtual address, valid with the strobe |

## Verification
On every cycle, the assertions check four things: the masked context bits after a strobe match the aligned address, the unmasked bits are kept, the word holds when idle, and the hardwired mask bits keep their constant value. They also check that the decoded lowest bit really is the bottom of the run. Only the bench scenarios can show the exact bit mapping for each recommended mask, the probe readback values, the priority between a write and a strobe on the same clock, and the one-clock delay before a mask write takes effect. The bench uses its own bit-by-bit model for these.

// File: rtl/ctx_pkg.sv
// Package: shared widths and the word type for the context pointer unit.
// Assumes a 32-bit register file word; all derived widths follow from it.
package ctx_pkg;
    localparam int unsigned CTX_XLEN = 32;
    localparam int unsigned CTX_IDXW = $clog2(CTX_XLEN);
    localparam int unsigned CTX_CNTW = $clog2(CTX_XLEN + 1);

    typedef logic [CTX_XLEN-1:0] ctx_word_t;
    typedef logic [CTX_IDXW-1:0] ctx_idx_t;
    typedef logic [CTX_CNTW-1:0] ctx_cnt_t;
endpackage

// File: rtl/ctx_mask_reg.sv
// Module: field-mask register. Bits flagged in IMPL_BITS are writable; the
// rest read back the matching bit of FIXED_BITS. Assumes software writes a
// contiguous run; non-contiguous values are stored but give no defined result.
module ctx_mask_reg
    import ctx_pkg::*;
#(
    parameter ctx_word_t IMPL_BITS  = 32'h3FFF_FFFC,
    parameter ctx_word_t FIXED_BITS = 32'h0000_0000,
    parameter ctx_word_t RESET_MASK = 32'h007F_FFF0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctx_word_t wr_data,
    output ctx_word_t mask_q
);
    localparam ctx_word_t HARD_VAL  = FIXED_BITS & ~IMPL_BITS;
    localparam ctx_word_t RESET_VAL = (RESET_MASK & IMPL_BITS) | HARD_VAL;

    ctx_word_t mask_r;

    // Store writable bits; hardwired bits are re-imposed on every load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_r <= RESET_VAL;
        else if (wr_en)
            mask_r <= (wr_data & IMPL_BITS) | HARD_VAL;
    end

    assign mask_q = mask_r;

    // R5
    hard_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_r & ~IMPL_BITS) == HARD_VAL);
endmodule

// File: rtl/ctx_mask_decode.sv
// Module: finds the lowest set bit and the population of the mask.
// Purely combinational; assumes a contiguous run so that the pair (lo, width)
// fully describes it.
module ctx_mask_decode
    import ctx_pkg::*;
(
    input  ctx_word_t mask,
    output ctx_idx_t  lo_bit,
    output ctx_cnt_t  width
);
    // Priority scan from bit 0 upward for the first set bit.
    always_comb begin
        logic found;
        found  = 1'b0;
        lo_bit = '0;
        for (int i = 0; i < CTX_XLEN; i++) begin
            if (!found && mask[i]) begin
                lo_bit = ctx_idx_t'(i);
                found  = 1'b1;
            end
        end
    end

    // Population count of the mask gives the field width.
    always_comb begin
        width = '0;
        for (int i = 0; i < CTX_XLEN; i++)
            width = width + ctx_cnt_t'(mask[i]);
    end
endmodule

// File: rtl/ctx_field_align.sv
// Module: places the top `width` bits of the faulting address at bit `lo_bit`
// and clears everything outside the mask. Width 0 yields zero.
module ctx_field_align
    import ctx_pkg::*;
(
    input  ctx_word_t vaddr,
    input  ctx_word_t mask,
    input  ctx_idx_t  lo_bit,
    input  ctx_cnt_t  width,
    output ctx_word_t field
);
    logic [CTX_CNTW:0] rshift;
    ctx_word_t         top_bits;

    // Right shift amount that keeps only the upper `width` address bits.
    assign rshift   = (CTX_CNTW + 1)'(CTX_XLEN) - {1'b0, width};
    // Drop the low address bits, then move the field up to its place.
    assign top_bits = vaddr >> rshift;
    assign field    = (top_bits << lo_bit) & mask;
endmodule

// File: rtl/ctx_value_reg.sv
// Module: context word. A software write sets the whole word; an exception in
// the same clock overrides the masked bits with the aligned address field.
module ctx_value_reg
    import ctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctx_word_t wr_data,
    input  logic      exc_valid,
    input  ctx_word_t mask,
    input  ctx_word_t field,
    output ctx_word_t ctx_q
);
    ctx_word_t ctx_r;
    ctx_word_t base;
    ctx_word_t ctx_next;

    // Select the software value or the held value as the unmasked source.
    assign base     = wr_en ? wr_data : ctx_r;
    // Merge the address field into the masked positions on an exception.
    assign ctx_next = exc_valid ? ((base & ~mask) | (field & mask)) : base;

    // Register the context word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctx_r <= '0;
        else
            ctx_r <= ctx_next;
    end

    assign ctx_q = ctx_r;

    // R2
    masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> ((ctx_r & $past(mask)) == ($past(field) & $past(mask))));
    // R3
    unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !wr_en) |=> ((ctx_r & ~$past(mask)) == ($past(ctx_r) & ~$past(mask))));
    // R8
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_valid) |=> (ctx_r == $past(wr_data)));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !exc_valid) |=> $stable(ctx_r));
endmodule

// File: rtl/ctx_ptr_unit.sv
// Module: top of the TLB context pointer updater. Holds the field mask and
// the context word; on a translation exception the masked context bits are
// loaded with the upper faulting-address bits in one clock.
// Assumes the exception strobe lasts one clock per event and masks are contiguous.
module ctx_ptr_unit
    import ctx_pkg::*;
#(
    parameter logic [31:0] MASK_IMPL  = 32'h3FFF_FFFC,
    parameter logic [31:0] MASK_FIXED = 32'h0000_0000,
    parameter logic [31:0] MASK_RESET = 32'h007F_FFF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        ctx_we,
    input  logic [31:0] ctx_wdata,
    output logic [31:0] ctx_rdata,
    input  logic        exc_valid,
    input  logic [31:0] exc_vaddr
);
    ctx_word_t mask;
    ctx_idx_t  lo_bit;
    ctx_cnt_t  width;
    ctx_word_t field;

    ctx_mask_reg #(
        .IMPL_BITS  (MASK_IMPL),
        .FIXED_BITS (MASK_FIXED),
        .RESET_MASK (MASK_RESET)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .mask_q  (mask)
    );

    ctx_mask_decode u_decode (
        .mask   (mask),
        .lo_bit (lo_bit),
        .width  (width)
    );

    ctx_field_align u_align (
        .vaddr  (exc_vaddr),
        .mask   (mask),
        .lo_bit (lo_bit),
        .width  (width),
        .field  (field)
    );

    ctx_value_reg u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctx_we),
        .wr_data   (ctx_wdata),
        .exc_valid (exc_valid),
        .mask      (mask),
        .field     (field),
        .ctx_q     (ctx_rdata)
    );

    assign cfg_rdata = mask;

    // R2: the decoded low bit sits at the bottom of the run
    lo_bit_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != '0) |-> (mask[lo_bit] && ((mask & ((ctx_word_t'(1) << lo_bit) - 1)) == '0)));
    // R2: decoded width agrees with the run length
    width_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(width) == $countones(mask));
    // R7
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (field == '0));
endmodule

// File: tb/tb_ctx_ptr_unit.sv
module tb_ctx_ptr_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] IMPL = 32'h3FFF_FFFC;

    typedef struct {
        logic [31:0] ctx;
        logic [31:0] cfg;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ctx_we = 1'b0;
    logic [31:0] ctx_wdata = '0;
    logic [31:0] ctx_rdata;
    logic        exc_valid = 1'b0;
    logic [31:0] exc_vaddr = '0;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] m_ctx;
    logic [31:0] m_cfg;
    bit          done = 1'b0;

    ctx_ptr_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata),
        .exc_valid(exc_valid), .exc_vaddr(exc_vaddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-by-bit model of the address field placement.
    function automatic logic [31:0] place_field(logic [31:0] m, logic [31:0] va);
        int lo = -1;
        int n = 0;
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                if (lo < 0) lo = i;
                n++;
            end
        end
        for (int i = 0; i < n; i++) r[lo+i] = va[32-n+i];
        return r;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Driver: applies one clock of stimulus and pushes the expected state.
    task automatic op(input bit cwe, input logic [31:0] cwd,
                      input bit xwe, input logic [31:0] xwd,
                      input bit ex, input logic [31:0] va, input string req);
        logic [31:0] base;
        logic [31:0] nctx;
        logic [31:0] ncfg;
        exp_t        e;
        @(negedge clk);
        cfg_we = cwe; cfg_wdata = cwd;
        ctx_we = xwe; ctx_wdata = xwd;
        exc_valid = ex; exc_vaddr = va;
        base = xwe ? xwd : m_ctx;
        nctx = ex ? ((base & ~m_cfg) | place_field(m_cfg, va)) : base;
        ncfg = cwe ? (cwd & IMPL) : m_cfg;
        @(posedge clk);
        m_ctx = nctx; m_cfg = ncfg;
        e.ctx = nctx; e.cfg = ncfg; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        cfg_we = 1'b0; ctx_we = 1'b0; exc_valid = 1'b0;
    endtask

    // Monitor: compares design state with the oldest expected item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (ctx_rdata !== e.ctx || cfg_rdata !== e.cfg) begin
                    n_errors++;
                    $display("FAIL %s: ctx=%h cfg=%h expected ctx=%h cfg=%h",
                             e.req, ctx_rdata, cfg_rdata, e.ctx, e.cfg);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end

    initial begin
        m_ctx = 32'h0;
        m_cfg = 32'h007F_FFF0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        op(0, 0, 0, 0, 0, 0, "R1");                           // reset state
        op(0, 0, 0, 0, 0, 0, "R9");                           // idle hold
        op(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R8");               // full ctx write
        op(0, 0, 0, 0, 1, 32'hABCD_E123, "R2");               // default mask load
        op(0, 0, 1, 32'h8000_0001, 0, 0, "R8");
        op(0, 0, 0, 0, 1, 32'h1234_5678, "R3");               // outside bits kept
        op(1, 32'h003F_FFF8, 0, 0, 0, 0, "R8");
        op(0, 0, 0, 0, 1, 32'hFEDC_BA98, "R4");               // 4K / 32-bit
        op(1, 32'h007F_FFF8, 0, 0, 0, 0, "R8");
        op(0, 0, 0, 0, 1, 32'h0F0F_F0F0, "R4");               // 2K / 32-bit
        op(1, 32'h00FF_FFF8, 0, 0, 0, 0, "R8");
        op(0, 0, 0, 0, 1, 32'hC3A5_5A3C, "R4");               // 1K / 32-bit
        op(1, 32'h0000_0000, 0, 0, 0, 0, "R5");               // probe zeros
        op(0, 0, 1, 32'h5555_AAAA, 1, 32'hFFFF_FFFF, "R7");   // zero mask
        op(0, 0, 0, 0, 1, 32'h7777_7777, "R7");
        op(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5");               // probe ones
        op(0, 0, 0, 0, 1, 32'h9ABC_DEF1, "R2");               // widest mask
        op(0, 0, 1, 32'h0123_4567, 1, 32'hDEAD_BEEF, "R6");   // same-clock priority
        op(1, 32'h007F_FFF0, 0, 0, 1, 32'h4567_89AB, "R8");   // old mask used
        op(0, 0, 0, 0, 1, 32'h4567_89AB, "R2");               // new mask used
        op(0, 0, 0, 0, 0, 0, "R9");
        @(posedge clk);
        #2;
        done = 1'b1;
        finish_run();
    end
endmodule